// File: doc/BRIEF.md
# Dual-Chamber Pacing Timing Core

This block holds the timing for a pacing mode that paces and senses both the upper and the lower heart chamber. It advances its interval timers once per 1 ms tick (`tick_i`), takes raw atrial and ventricular detection pulses, and returns one-clock event pulses. The outputs are atrial sense, atrial refractory sense, atrial pace, ventricular sense and ventricular pace. Five interval rules interact:

- a lower-rate bound on the ventricular interval;
- an atrioventricular (AV) delay;
- an upper-rate bound on ventricular pacing;
- a post-ventricular atrial blanking and refractory window;
- a ventricular refractory window.

Every interval is a fixed parameter. All intervals are counted in ticks.

Time moves only on cycles where `tick_i` is high. Detections are sampled only on those cycles, and event pulses come out one clock after such a cycle. All pins are plain control pins. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. A detection that falls on a cycle without a tick is lost, so the source should hold or align detections with the tick.

Top module: `pace_core`

## Requirements
- R1: While reset is held, all five outputs are low. After reset, the timers stand as if a ventricular event had just occurred, and no pace is pending. With no detections, the first atrial pace therefore comes at tick T_LRI−T_AVD.
- R2: An atrial pace is issued when T_LRI−T_AVD ticks have elapsed since the last ventricular event, unless an atrial sense has already started an AV delay in this cycle. It is also skipped if an atrial sense falls on that same tick.
- R3: A ventricular pace is issued T_AVD ticks after an atrial sense or atrial pace. A valid ventricular sense before then cancels the pending pace. Ventricular sense and pace both restart the ventricular interval.
- R4: If the AV delay expires before T_URI ticks have passed since the last ventricular event, the ventricular pace is held. It is issued on the tick where T_URI is reached.
- R5: An atrial detection at n ticks after the last ventricular event is classified as follows:
  - n ≤ T_ABL: discarded.
  - T_ABL < n ≤ T_ARP: gives an atrial refractory pulse only.
  - n > T_ARP: gives an atrial sense.
- R6: A ventricular detection at n ≤ T_VRP ticks after the last ventricular event is discarded. At n > T_VRP it gives a ventricular sense.
- R7: While an AV delay is running, atrial detections outside the refractory window are ignored, and no atrial pace is issued.
- R8: Each output pulse is exactly one clock wide. When a sense and a pace for the same chamber fall on the same tick, only the sense is issued.
- R9: On cycles without a tick, no timer advances and detections are ignored. Every output pulse follows a tick cycle.
- R10: The ventricular interval never exceeds T_LRI ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 1 ms time base strobe |
| atr_det_i | input | 1 | Raw atrial detection |
| ven_det_i | input | 1 | Raw ventricular detection |
| a_sense_o | output | 1 | Atrial sense pulse |
| a_refr_o | output | 1 | Atrial refractory sense pulse |
| a_pace_o | output | 1 | Atrial pace pulse |
| v_sense_o | output | 1 | Ventricular sense pulse |
| v_pace_o | output | 1 | Ventricular pace pulse |

## Verification
The assertions watch a tick counter of their own, which restarts on each ventricular output. On every cycle they check four things against it:

- the upper-rate spacing of ventricular paces;
- the lower-rate ceiling on the ventricular interval;
- the refractory floors for ventricular sense and for atrial sense or refractory pulses;
- the exclusion rules between same-chamber outputs, and that outputs appear only after tick cycles.

Some behaviour only the bench scenarios can show, because it depends on exact tick placement:

- the exact tick on which a pace is scheduled, held or cancelled;
- the three-way atrial split at its boundary ticks;
- that a blocked detection leaves the following pace schedule unchanged.

// File: rtl/pace_pkg.sv
package pace_pkg;

  typedef struct packed {
    logic v_pace;
    logic v_sense;
    logic a_pace;
    logic a_refr;
    logic a_sense;
  } pace_ev_t;

  localparam pace_ev_t PACE_EV_NONE = '{default: 1'b0};

endpackage

// File: rtl/pace_v_timer.sv
// Ventricular interval timer: ticks since the last ventricular event.
module pace_v_timer #(
  parameter int CW    = 10,
  parameter int T_LRI = 1000,
  parameter int T_AVD = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          v_evt_i,
  output logic [CW-1:0] v_now_o,
  output logic          ap_due_o
);
  localparam logic [CW-1:0] K_AP  = CW'(T_LRI - T_AVD);
  localparam logic [CW-1:0] K_LRI = CW'(T_LRI);

  logic [CW-1:0] v_cnt;

  // elapsed time as seen on the current tick, saturating
  assign v_now_o  = (v_cnt == '1) ? v_cnt : v_cnt + 1'b1;
  assign ap_due_o = (v_now_o == K_AP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_cnt <= '0;
    end else if (tick_i) begin
      v_cnt <= v_evt_i ? '0 : v_now_o;
    end
  end

  // the scheduler must always close the interval by T_LRI
  assert_interval_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt <= K_LRI);

endmodule

// File: rtl/pace_av_timer.sv
// AV delay timer with upper-rate hold of the ventricular pace.
module pace_av_timer #(
  parameter int CW    = 10,
  parameter int AW    = 8,
  parameter int T_AVD = 150,
  parameter int T_URI = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          a_evt_i,
  input  logic          v_evt_i,
  input  logic [CW-1:0] v_now_i,
  output logic          busy_o,
  output logic          vp_due_o
);
  localparam logic [AW-1:0] K_AVD = AW'(T_AVD);
  localparam logic [CW-1:0] K_URI = CW'(T_URI);

  logic          av_act;
  logic [AW-1:0] av_cnt;
  logic [AW-1:0] av_now;

  assign av_now   = (av_cnt == '1) ? av_cnt : av_cnt + 1'b1;
  assign busy_o   = av_act;
  // expired AV delay is only honoured once the upper-rate bound is met
  assign vp_due_o = av_act && (av_now >= K_AVD) && (v_now_i >= K_URI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      av_act <= 1'b0;
      av_cnt <= '0;
    end else if (tick_i) begin
      if (v_evt_i) begin
        av_act <= 1'b0;
        av_cnt <= '0;
      end else if (a_evt_i) begin
        av_act <= 1'b1;
        av_cnt <= '0;
      end else if (av_act) begin
        av_cnt <= av_now;
      end
    end
  end

  // an atrial event may only open a new AV delay, never restart one
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && a_evt_i) |-> !av_act);

endmodule

// File: rtl/pace_atrial_gate.sv
// Three-way split of atrial detections against the post-ventricular windows.
module pace_atrial_gate #(
  parameter int CW    = 10,
  parameter int T_ABL = 50,
  parameter int T_ARP = 100
) (
  input  logic          det_i,
  input  logic [CW-1:0] v_now_i,
  input  logic          av_busy_i,
  output logic          sense_o,
  output logic          refr_o
);
  localparam logic [CW-1:0] K_ABL = CW'(T_ABL);
  localparam logic [CW-1:0] K_ARP = CW'(T_ARP);

  logic in_blank;
  logic in_refr;

  always_comb begin
    in_blank = (v_now_i <= K_ABL);
    in_refr  = !in_blank && (v_now_i <= K_ARP);
    refr_o   = det_i && in_refr;
    sense_o  = det_i && !in_blank && !in_refr && !av_busy_i;
  end

endmodule

// File: rtl/pace_vent_gate.sv
// Ventricular refractory filter.
module pace_vent_gate #(
  parameter int CW    = 10,
  parameter int T_VRP = 150
) (
  input  logic          det_i,
  input  logic [CW-1:0] v_now_i,
  output logic          sense_o
);
  localparam logic [CW-1:0] K_VRP = CW'(T_VRP);

  assign sense_o = det_i && (v_now_i > K_VRP);

endmodule

// File: rtl/pace_core.sv
module pace_core
  import pace_pkg::*;
#(
  parameter int T_AVD = 150,
  parameter int T_LRI = 1000,
  parameter int T_ARP = 100,
  parameter int T_VRP = 150,
  parameter int T_URI = 400,
  parameter int T_ABL = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic atr_det_i,
  input  logic ven_det_i,
  output logic a_sense_o,
  output logic a_refr_o,
  output logic a_pace_o,
  output logic v_sense_o,
  output logic v_pace_o
);
  localparam int CW = $clog2(T_LRI + 2);
  localparam int AW = $clog2(T_AVD + 2);

  logic [CW-1:0] v_now;
  logic          ap_due;
  logic          av_busy;
  logic          vp_due;
  logic          a_sen_raw;
  logic          a_ref_raw;
  logic          v_sen_raw;
  logic          a_evt;
  logic          v_evt;
  pace_ev_t      ev_d;
  pace_ev_t      ev_q;

  pace_v_timer #(.CW(CW), .T_LRI(T_LRI), .T_AVD(T_AVD)) u_vtmr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .v_evt_i(v_evt),
    .v_now_o(v_now), .ap_due_o(ap_due)
  );

  pace_av_timer #(.CW(CW), .AW(AW), .T_AVD(T_AVD), .T_URI(T_URI)) u_avtmr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .a_evt_i(a_evt),
    .v_evt_i(v_evt), .v_now_i(v_now), .busy_o(av_busy), .vp_due_o(vp_due)
  );

  pace_atrial_gate #(.CW(CW), .T_ABL(T_ABL), .T_ARP(T_ARP)) u_agate (
    .det_i(atr_det_i), .v_now_i(v_now), .av_busy_i(av_busy),
    .sense_o(a_sen_raw), .refr_o(a_ref_raw)
  );

  pace_vent_gate #(.CW(CW), .T_VRP(T_VRP)) u_vgate (
    .det_i(ven_det_i), .v_now_i(v_now), .sense_o(v_sen_raw)
  );

  // event resolution for the current tick; senses win over paces
  always_comb begin
    ev_d         = PACE_EV_NONE;
    ev_d.a_sense = tick_i && a_sen_raw;
    ev_d.a_refr  = tick_i && a_ref_raw;
    ev_d.v_sense = tick_i && v_sen_raw;
    ev_d.v_pace  = tick_i && vp_due && !ev_d.v_sense;
    ev_d.a_pace  = tick_i && ap_due && !av_busy && !ev_d.a_sense
                   && !ev_d.v_sense && !ev_d.v_pace;
  end

  assign v_evt = ev_d.v_sense || ev_d.v_pace;
  assign a_evt = ev_d.a_sense || ev_d.a_pace;

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= PACE_EV_NONE;
    else        ev_q <= ev_d;
  end

  assign a_sense_o = ev_q.a_sense;
  assign a_refr_o  = ev_q.a_refr;
  assign a_pace_o  = ev_q.a_pace;
  assign v_sense_o = ev_q.v_sense;
  assign v_pace_o  = ev_q.v_pace;

  // ---------------------------------------------------------------
  // Assertions: independent tick count since the last ventricular output
  logic [CW:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                    chk_gap <= '0;
    else if (v_sense_o || v_pace_o) chk_gap <= tick_i ? (CW+1)'(1) : '0;
    else if (tick_i && chk_gap != '1) chk_gap <= chk_gap + 1'b1;
  end

  assert_pace_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v_pace_o |-> (chk_gap >= (CW+1)'(T_URI)));

  assert_lower_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_gap <= (CW+1)'(T_LRI));

  assert_vent_refractory_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_sense_o |-> (chk_gap > (CW+1)'(T_VRP)));

  assert_atrial_windows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sense_o |-> (chk_gap > (CW+1)'(T_ARP))) and
    (a_refr_o |-> (chk_gap > (CW+1)'(T_ABL))));

  assert_atrial_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_sense_o, a_refr_o, a_pace_o}));

  assert_vent_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({v_sense_o, v_pace_o}));

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sense_o || a_refr_o || a_pace_o || v_sense_o || v_pace_o) |-> $past(tick_i));

endmodule

// File: tb/pace_core_tb.sv
module pace_core_tb;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic atr_det_i = 1'b0;
  logic ven_det_i = 1'b0;
  logic a_sense_o, a_refr_o, a_pace_o, v_sense_o, v_pace_o;

  int cyc = 0;
  int all_cyc = 0;
  int total = 0;
  int bad = 0;
  exp_t sb[$];
  string knames[5] = '{"AS", "AR", "AP", "VS", "VP"};
  logic [4:0] obs;

  always #5 clk = ~clk;

  pace_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .atr_det_i(atr_det_i), .ven_det_i(ven_det_i),
    .a_sense_o(a_sense_o), .a_refr_o(a_refr_o), .a_pace_o(a_pace_o),
    .v_sense_o(v_sense_o), .v_pace_o(v_pace_o)
  );

  assign obs = {v_pace_o, v_sense_o, a_pace_o, a_refr_o, a_sense_o};

  always @(posedge clk) begin
    all_cyc <= all_cyc + 1;
    if (rst_n) cyc <= cyc + 1;
  end

  task automatic expect_ev(input int kind, input int c, input string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: every observed pulse is matched against the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 5; k++) begin
        if (obs[k]) begin
          total++;
          if (sb.size() == 0) begin
            bad++;
            $display("FAIL unexpected: actual %s@%0d expected none", knames[k], cyc);
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
              bad++;
              $display("FAIL %s: actual %s@%0d expected %s@%0d",
                       e.req, knames[k], cyc, knames[e.kind], e.cyc);
            end
          end
        end
      end
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic pulse_a(input int c);
    wait_cyc(c - 1);
    atr_det_i = 1'b1;
    @(negedge clk);
    atr_det_i = 1'b0;
  endtask

  task automatic pulse_v(input int c);
    wait_cyc(c - 1);
    ven_det_i = 1'b1;
    @(negedge clk);
    ven_det_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(negedge clk) begin
    if (all_cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual cycle %0d expected end by 20000", all_cyc);
      finish_run();
    end
  end

  initial begin
    // kinds: 0 AS, 1 AR, 2 AP, 3 VS, 4 VP
    expect_ev(2,  850, "R1");   // first AP after reset, no activity
    expect_ev(4, 1000, "R3");   // VP one AV delay after AP (R2 cycle)
    expect_ev(0, 1300, "R5");   // AS outside refractory
    expect_ev(4, 1450, "R3");   // AV after AS; AP at 1850 suppressed (R2)
    expect_ev(0, 1950, "R5");
    expect_ev(3, 2000, "R3");   // VS cancels pending VP
    expect_ev(0, 2200, "R4");
    expect_ev(4, 2400, "R4");   // AV expires at 2350, held to URI
    expect_ev(1, 2451, "R5");   // first tick past blanking
    expect_ev(1, 2480, "R5");
    expect_ev(1, 2500, "R5");   // last tick of refractory window
    expect_ev(2, 3250, "R2");   // refractory pulses did not start AV
    expect_ev(4, 3400, "R6");   // vdet at 2550 discarded
    expect_ev(3, 3551, "R6");   // first tick past ventricular refractory
    expect_ev(0, 3851, "R7");
    expect_ev(4, 4001, "R7");   // atrial det at 3900 ignored
    expect_ev(0, 4501, "R8");
    expect_ev(3, 4651, "R8");   // sense beats pace due on same tick
    expect_ev(0, 5501, "R8");   // sense beats atrial pace on same tick
    expect_ev(4, 5651, "R8");
    expect_ev(2, 6601, "R9");   // 100 missing ticks shift AP
    expect_ev(4, 6751, "R9");

    repeat (4) @(negedge clk);
    total++;
    if (obs !== 5'b0) begin
      bad++;
      $display("FAIL R1: actual outputs %b expected 00000 in reset", obs);
    end
    tick_i = 1'b1;
    rst_n  = 1'b1;

    pulse_a(1300);
    pulse_a(1950);
    pulse_v(2000);
    pulse_a(2200);
    pulse_a(2430);              // blanked (R5)
    pulse_a(2450);              // last blanked tick (R5)
    pulse_a(2451);
    pulse_a(2480);
    pulse_a(2500);
    pulse_v(2550);              // inside ventricular refractory (R6)
    pulse_v(3551);
    pulse_a(3851);
    pulse_a(3900);              // AV running (R7)
    pulse_a(4501);
    pulse_v(4651);
    pulse_a(5501);

    // R9: tick held low for edges 5701..5800, detection in the gap ignored
    wait_cyc(5700);
    tick_i = 1'b0;
    pulse_a(5750);
    wait_cyc(5800);
    total++;
    if (obs !== 5'b0) begin
      bad++;
      $display("FAIL R9: actual outputs %b expected 00000 without tick", obs);
    end
    tick_i = 1'b1;

    wait_cyc(6900);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL %s: actual missing %s expected at %0d",
               sb[0].req, knames[sb[0].kind], sb[0].cyc);
    end
    finish_run();
  end

endmodule